// File: doc/BRIEF.md
# Correlated-Error Oscillator Tuning Loop

This block closes the digital part of a frequency-tuning loop for an oscillator that is locked by periodic pulse injection. Once per reference period a time-to-digital converter reports two 8-bit period readings. The first reading is the period of the cycle that received the injection pulse. The second is the period of an ordinary free-running cycle. Their difference is the loop error. It is zero only when the oscillator's natural frequency sits on the wanted multiple of the reference.

The block subtracts each pair of readings. It can sum that difference over M reference periods and emit one value per window, which lowers the rate of everything downstream. It scales the result by a programmable arithmetic right shift, which sets the loop bandwidth. It then integrates the result in a saturating accumulator. A first-order noise-shaping quantiser turns the wide integrator value into an 8-bit code. That code goes out in the upper bits of a 16-bit DAC word, with a one-cycle strobe. The DAC, its filter and the converter that makes the readings lie outside the block.

Top module: `dtl_tuning_loop`

## Requirements
- R1: While reset is high and on the first cycle after it, `dac_vld` and `pair_err` are 0 and `dac_code` is 0. The integrator and the quantiser error both start at 0.
- R2: A pair completes when `second_vld` arrives while a first reading is pending. Its error is the signed 9-bit value `meas_first - meas_second`, using the pending first reading. Completing the pair clears the pending state.
- R3: A `second_vld` with no pending first reading is discarded. It drives `pair_err` high for exactly the next cycle, and no output is produced for it.
- R4: When `first_vld` and `second_vld` arrive in the same cycle, the second reading is judged against the reading that was pending before that cycle. The new first reading then becomes the pending one.
- R5: Errors are summed over a window of M completed pairs, and one sum leaves per window. M is taken from `decim_m`. A value of 0 is treated as 1, and M = 1 passes every pair straight through.
- R6: A new `decim_m` is taken up only when a window closes. The window that is open keeps its old length.
- R7: Each window sum is shifted right arithmetically by `gain_shift` bits before it is integrated. The shift keeps the sign and rounds toward minus infinity.
- R8: The 16-bit signed integrator clamps at +32767 and −32768 instead of wrapping.
- R9: The quantiser works on the offset-binary value `integrator + 32768`, to which it adds the 8-bit error it carries. Bits [16:8] of that 17-bit sum, clamped at 255, give the code. Bits [7:0] become the new carried error.
- R10: `dac_code` is {code, 8'h00}, so its low 8 bits are always 0. `dac_vld` pulses for one cycle, four clock edges after the edge that samples the completing `second_vld`. `dac_code` changes only together with `dac_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_first | input | 8 | Injected-cycle period reading |
| first_vld | input | 1 | Strobe for `meas_first` |
| meas_second | input | 8 | Free-running-cycle period reading |
| second_vld | input | 1 | Strobe for `meas_second` |
| decim_m | input | 8 | Window length M (0 acts as 1) |
| gain_shift | input | 4 | Arithmetic right-shift amount for loop gain |
| dac_code | output | 16 | DAC word, quantised code in the upper 8 bits |
| dac_vld | output | 1 | One-cycle strobe for a new `dac_code` |
| pair_err | output | 1 | One-cycle flag for a discarded out-of-order reading |

## Verification
Two pairs of functions can fall in one cycle. Pair completion and a new first capture meet when both strobes are driven together. The out-of-order flag and that capture meet the same way when nothing is pending. The bench drives both strobes on one edge and then a lone second reading. It judges the result by the pulse on `pair_err` and by the exact DAC code that the retained first reading produces. The second pair is a window closing in the same cycle that `decim_m` changes. This is provoked by changing M in the middle of a window, and it is judged by counting DAC strobes across the following pairs.

// File: rtl/dtl_pkg.sv
package dtl_pkg;
  // Capture state of the reading-pair front end
  typedef enum logic {
    PAIR_IDLE  = 1'b0,
    PAIR_ARMED = 1'b1
  } pair_state_e;
endpackage

// File: rtl/dtl_correlator.sv
module dtl_correlator
  import dtl_pkg::*;
#(
  parameter int MEAS_W  = 8,
  localparam int DIFF_W = MEAS_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [MEAS_W-1:0]        meas_first,
  input  logic                     first_vld,
  input  logic [MEAS_W-1:0]        meas_second,
  input  logic                     second_vld,
  output logic signed [DIFF_W-1:0] diff,
  output logic                     diff_vld,
  output logic                     pair_err
);
  pair_state_e       state_q;
  logic [MEAS_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PAIR_IDLE;
      held_q   <= '0;
      diff     <= '0;
      diff_vld <= 1'b0;
      pair_err <= 1'b0;
    end else begin
      diff_vld <= 1'b0;
      pair_err <= 1'b0;
      // the second reading is judged against what was pending before this edge
      if (second_vld) begin
        if (state_q == PAIR_ARMED) begin
          diff     <= $signed({1'b0, held_q}) - $signed({1'b0, meas_second});
          diff_vld <= 1'b1;
          state_q  <= PAIR_IDLE;
        end else begin
          pair_err <= 1'b1;
        end
      end
      // a new first reading always becomes the pending one
      if (first_vld) begin
        held_q  <= meas_first;
        state_q <= PAIR_ARMED;
      end
    end
  end
endmodule

// File: rtl/dtl_decimator.sv
module dtl_decimator #(
  parameter int DIFF_W  = 9,
  parameter int M_W     = 8,
  localparam int SUM_W  = DIFF_W + M_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DIFF_W-1:0] diff,
  input  logic                     diff_vld,
  input  logic [M_W-1:0]           decim_m,
  output logic signed [SUM_W-1:0]  win_sum,
  output logic                     win_vld
);
  logic [M_W-1:0]          len_q;
  logic [M_W-1:0]          cnt_q;
  logic signed [SUM_W-1:0] acc_q;
  logic [M_W-1:0]          len_next;
  logic signed [SUM_W-1:0] acc_add;

  assign len_next = (decim_m == '0) ? M_W'(1) : decim_m;
  assign acc_add  = acc_q + {{M_W{diff[DIFF_W-1]}}, diff};

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q   <= len_next;
      cnt_q   <= '0;
      acc_q   <= '0;
      win_sum <= '0;
      win_vld <= 1'b0;
    end else begin
      win_vld <= 1'b0;
      if (diff_vld) begin
        if (cnt_q == len_q - 1'b1) begin
          win_sum <= acc_add;
          win_vld <= 1'b1;
          acc_q   <= '0;
          cnt_q   <= '0;
          len_q   <= len_next;  // window length only changes here
        end else begin
          acc_q <= acc_add;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dtl_integrator.sv
module dtl_integrator #(
  parameter int IN_W    = 17,
  parameter int INT_W   = 16,
  parameter int SH_W    = 4,
  localparam int WIDE_W = ((IN_W > INT_W) ? IN_W : INT_W) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [IN_W-1:0]  win_sum,
  input  logic                    win_vld,
  input  logic [SH_W-1:0]         gain_shift,
  output logic signed [INT_W-1:0] integ,
  output logic                    integ_vld
);
  localparam logic signed [WIDE_W-1:0] HI_LIM =
    {{(WIDE_W-INT_W+1){1'b0}}, {(INT_W-1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] LO_LIM =
    {{(WIDE_W-INT_W+1){1'b1}}, {(INT_W-1){1'b0}}};

  logic signed [IN_W-1:0]   scaled;
  logic signed [WIDE_W-1:0] total;
  logic signed [INT_W-1:0]  clamped;

  assign scaled = win_sum >>> gain_shift;
  assign total  = {{(WIDE_W-INT_W){integ[INT_W-1]}}, integ}
                + {{(WIDE_W-IN_W){scaled[IN_W-1]}}, scaled};

  always_comb begin
    if (total > HI_LIM)      clamped = HI_LIM[INT_W-1:0];
    else if (total < LO_LIM) clamped = LO_LIM[INT_W-1:0];
    else                     clamped = total[INT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ     <= '0;
      integ_vld <= 1'b0;
    end else begin
      integ_vld <= win_vld;
      if (win_vld) integ <= clamped;
    end
  end
endmodule

// File: rtl/dtl_sigma_delta.sv
module dtl_sigma_delta #(
  parameter int INT_W  = 16,
  parameter int CODE_W = 8,
  localparam int FRAC_W = INT_W - CODE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [INT_W-1:0] integ,
  input  logic                    integ_vld,
  output logic [CODE_W-1:0]       code,
  output logic                    code_vld
);
  logic [FRAC_W-1:0] resid_q;
  logic [INT_W-1:0]  ubin;
  logic [INT_W:0]    total;
  logic [CODE_W:0]   upper;

  assign ubin  = {~integ[INT_W-1], integ[INT_W-2:0]};
  assign total = {1'b0, ubin} + {{(CODE_W+1){1'b0}}, resid_q};
  assign upper = total[INT_W -: CODE_W+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      resid_q  <= '0;
      code     <= '0;
      code_vld <= 1'b0;
    end else begin
      code_vld <= integ_vld;
      if (integ_vld) begin
        code    <= upper[CODE_W] ? {CODE_W{1'b1}} : upper[CODE_W-1:0];
        resid_q <= total[FRAC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dtl_tuning_loop.sv
module dtl_tuning_loop #(
  parameter int MEAS_W  = 8,
  parameter int M_W     = 8,
  parameter int SH_W    = 4,
  parameter int INT_W   = 16,
  parameter int CODE_W  = 8,
  parameter int DAC_W   = 16,
  localparam int DIFF_W = MEAS_W + 1,
  localparam int SUM_W  = DIFF_W + M_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MEAS_W-1:0] meas_first,
  input  logic              first_vld,
  input  logic [MEAS_W-1:0] meas_second,
  input  logic              second_vld,
  input  logic [M_W-1:0]    decim_m,
  input  logic [SH_W-1:0]   gain_shift,
  output logic [DAC_W-1:0]  dac_code,
  output logic              dac_vld,
  output logic              pair_err
);
  logic signed [DIFF_W-1:0] diff;
  logic                     diff_vld;
  logic signed [SUM_W-1:0]  win_sum;
  logic                     win_vld;
  logic signed [INT_W-1:0]  integ;
  logic                     integ_vld;
  logic [CODE_W-1:0]        sd_code;

  dtl_correlator #(.MEAS_W(MEAS_W)) u_corr (
    .clk(clk), .rst(rst),
    .meas_first(meas_first), .first_vld(first_vld),
    .meas_second(meas_second), .second_vld(second_vld),
    .diff(diff), .diff_vld(diff_vld), .pair_err(pair_err)
  );

  dtl_decimator #(.DIFF_W(DIFF_W), .M_W(M_W)) u_decim (
    .clk(clk), .rst(rst),
    .diff(diff), .diff_vld(diff_vld), .decim_m(decim_m),
    .win_sum(win_sum), .win_vld(win_vld)
  );

  dtl_integrator #(.IN_W(SUM_W), .INT_W(INT_W), .SH_W(SH_W)) u_integ (
    .clk(clk), .rst(rst),
    .win_sum(win_sum), .win_vld(win_vld), .gain_shift(gain_shift),
    .integ(integ), .integ_vld(integ_vld)
  );

  dtl_sigma_delta #(.INT_W(INT_W), .CODE_W(CODE_W)) u_sd (
    .clk(clk), .rst(rst),
    .integ(integ), .integ_vld(integ_vld),
    .code(sd_code), .code_vld(dac_vld)
  );

  // code sits in the most significant bits of the DAC word
  generate
    if (DAC_W > CODE_W) begin : g_pad
      assign dac_code = {sd_code, {(DAC_W-CODE_W){1'b0}}};
    end else begin : g_trim
      assign dac_code = sd_code[CODE_W-1 -: DAC_W];
    end
  endgenerate
endmodule

// File: rtl/dtl_tuning_loop_chk.sv
module dtl_tuning_loop_chk #(
  parameter int DAC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             second_vld,
  input logic [DAC_W-1:0] dac_code,
  input logic             dac_vld,
  input logic             pair_err
);
  // R10: low byte of every DAC word is zero
  p_low_zero_r10: assert property (@(posedge clk) disable iff (rst)
    dac_vld |-> (dac_code[7:0] == 8'h00));

  // R3: an error flag is always caused by a second strobe one edge earlier
  p_err_cause_r3: assert property (@(posedge clk) disable iff (rst)
    pair_err |-> $past(second_vld));

  // R10: every DAC strobe traces back to a completing second strobe four edges earlier
  p_out_cause_r10: assert property (@(posedge clk) disable iff (rst)
    dac_vld |-> $past(second_vld, 4));

  // R10: the DAC word only moves together with its strobe
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_code) |-> dac_vld);
endmodule

bind dtl_tuning_loop dtl_tuning_loop_chk #(.DAC_W(DAC_W)) u_chk (
  .clk(clk), .rst(rst), .second_vld(second_vld),
  .dac_code(dac_code), .dac_vld(dac_vld), .pair_err(pair_err)
);

// File: tb/dtl_tuning_loop_tb_top.sv
module dtl_tuning_loop_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  meas_first = '0;
  logic        first_vld = 1'b0;
  logic [7:0]  meas_second = '0;
  logic        second_vld = 1'b0;
  logic [7:0]  decim_m = 8'd1;
  logic [3:0]  gain_shift = '0;
  logic [15:0] dac_code;
  logic        dac_vld;
  logic        pair_err;

  int nchk = 0;
  int nfail = 0;
  int nvld = 0;
  logic [15:0] last_code = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dtl_tuning_loop dut_i (
    .clk(clk), .rst(rst),
    .meas_first(meas_first), .first_vld(first_vld),
    .meas_second(meas_second), .second_vld(second_vld),
    .decim_m(decim_m), .gain_shift(gain_shift),
    .dac_code(dac_code), .dac_vld(dac_vld), .pair_err(pair_err)
  );

  always @(negedge clk) begin
    if (dac_vld) begin
      nvld = nvld + 1;
      last_code = dac_code;
    end
  end

  // {first, second, expected code} with M=1, shift 0, from a cleared loop
  localparam logic [23:0] VEC [6] = '{
    {8'd100, 8'd90,  8'd128},
    {8'd50,  8'd250, 8'd127},
    {8'd255, 8'd0,   8'd128},
    {8'd0,   8'd255, 8'd127},
    {8'd200, 8'd200, 8'd128},
    {8'd255, 8'd55,  8'd128}
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] m, input logic [3:0] sh);
    @(negedge clk);
    decim_m = m;
    gain_shift = sh;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // returns at the negedge after the edge that samples the second strobe
  task automatic send_pair(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    meas_first = a; first_vld = 1'b1;
    @(negedge clk);
    first_vld = 1'b0;
    meas_second = b; second_vld = 1'b1;
    @(negedge clk);
    second_vld = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int base;
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 dac_vld in reset", dac_vld, 0);
    chk("R1 pair_err in reset", pair_err, 0);
    do_reset(8'd1, 4'd0);
    chk("R1 dac_code after reset", dac_code, 0);
    chk("R1 dac_vld after reset", dac_vld, 0);

    // R2, R9, R10: table of pairs
    for (int i = 0; i < 6; i++) begin
      base = nvld;
      send_pair(VEC[i][23:16], VEC[i][15:8]);
      settle();
      chk("R2 one strobe per pair", nvld - base, 1);
      chk("R9 R10 quantised code", last_code, {VEC[i][7:0], 8'h00});
    end
    // loop state now: integrator 10, carried error 27

    // R3: lone second reading is discarded and flagged
    base = nvld;
    @(negedge clk);
    meas_second = 8'd7; second_vld = 1'b1;
    @(negedge clk);
    second_vld = 1'b0;
    chk("R3 pair_err pulse", pair_err, 1);
    @(negedge clk);
    chk("R3 pair_err one cycle", pair_err, 0);
    settle();
    chk("R3 no output for discarded reading", nvld - base, 0);

    // R4: both strobes together with nothing pending, then a lone second
    @(negedge clk);
    meas_first = 8'd0; first_vld = 1'b1;
    meas_second = 8'd0; second_vld = 1'b1;
    @(negedge clk);
    first_vld = 1'b0; second_vld = 1'b0;
    chk("R4 simultaneous strobes flag error", pair_err, 1);
    meas_second = 8'd255; second_vld = 1'b1;
    @(negedge clk);
    second_vld = 1'b0;
    chk("R4 retained first completes pair", pair_err, 0);
    settle();
    chk("R4 code from retained first", last_code, 16'h7F00);

    // R5, R6: windows of four, then M changed mid-window
    do_reset(8'd4, 4'd0);
    base = nvld;
    for (int i = 0; i < 3; i++) send_pair(8'd150, 8'd50);
    settle();
    chk("R5 no output inside window", nvld - base, 0);
    send_pair(8'd150, 8'd50);
    settle();
    chk("R5 one output per window", nvld - base, 1);
    chk("R5 window sum code", last_code, 16'h8100);
    decim_m = 8'd1;
    for (int i = 0; i < 3; i++) send_pair(8'd150, 8'd50);
    settle();
    chk("R6 open window keeps old length", nvld - base, 1);
    send_pair(8'd150, 8'd50);
    settle();
    chk("R6 window closes at old length", nvld - base, 2);
    chk("R6 second window code", last_code, 16'h8300);
    send_pair(8'd150, 8'd50);
    settle();
    chk("R6 new length after boundary", nvld - base, 3);
    chk("R6 code after new length", last_code, 16'h8400);
    decim_m = 8'd0;
    send_pair(8'd150, 8'd50);
    settle();
    send_pair(8'd150, 8'd50);
    settle();
    chk("R5 M of zero acts as one", nvld - base, 5);

    // R7, R10: gain shift of 8 and exact latency
    do_reset(8'd1, 4'd8);
    send_pair(8'd255, 8'd0);
    chk("R10 no strobe after 1 edge", dac_vld, 0);
    @(negedge clk);
    chk("R10 no strobe after 2 edges", dac_vld, 0);
    @(negedge clk);
    chk("R10 no strobe after 3 edges", dac_vld, 0);
    @(negedge clk);
    chk("R10 strobe after 4 edges", dac_vld, 1);
    @(negedge clk);
    chk("R10 strobe lasts one cycle", dac_vld, 0);
    settle();
    chk("R7 shifted positive error", last_code, 16'h8000);
    send_pair(8'd0, 8'd255);
    settle();
    chk("R7 arithmetic shift of negative error", last_code, 16'h7F00);

    // R8: saturation at both ends
    do_reset(8'd1, 4'd0);
    for (int i = 0; i < 140; i++) send_pair(8'd255, 8'd0);
    settle();
    chk("R8 R9 positive clamp code", last_code, 16'hFF00);
    send_pair(8'd0, 8'd255);
    settle();
    chk("R8 no wrap after top clamp", last_code, 16'hFF00);
    for (int i = 0; i < 300; i++) send_pair(8'd0, 8'd255);
    settle();
    chk("R8 negative clamp code", last_code, 16'h0000);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule